// File: doc/BRIEF.md
# DSP Multiply-Accumulate Engine

A fixed-point arithmetic datapath that multiplies two 16-bit operands and folds the result into one of two 40-bit accumulators. Each operand is widened to 17 bits, by sign or by zero, before the multiply, so the same multiplier serves both signed and unsigned data. In fractional mode the product is doubled, which aligns Q15 by Q15 results to Q31. The eight guard bits above bit 31 let long sums run without loss. Saturation can clamp either accumulator at the 32-bit boundary or at the full 40-bit boundary.

Each clock takes one operation, aimed at accumulator A or B. The operations are: load a product, add or subtract a product, clear, add or subtract the other accumulator, and negate. The updated value and its overflow and saturation pulses are visible after the next rising edge. A combinational read-back port reduces either accumulator to a 16-bit word. It rounds half up or half to even, and can optionally clamp to the 16-bit signed range.

Top module: `dsp_mac_core`

## Requirements
- R1: While `rst_n` is low, and after it is released, both accumulators read zero and all four event pulses are low.
- R2: Op code 1 (load product) sets the selected accumulator (`acc_sel` 0 = A, 1 = B) to x*y, extended to 40 bits. When `cfg_unsigned` is 0 both operands are taken as signed. When it is 1 both are zero-extended.
- R3: With `cfg_frac` = 1 every product used by op codes 1, 2 and 3 is twice the integer product.
- R4: Op code 2 adds the product to the selected accumulator and op code 3 subtracts it. The other accumulator keeps its value.
- R5: Op code 4 zeroes the selected accumulator. With `op_valid` low, or with op code 0, neither accumulator changes.
- R6: Op code 5 adds the other accumulator into the selected one. Op code 6 subtracts the other from the selected one. Op code 7 replaces the selected one with its negation.
- R7: An overflow pulse for the target accumulator is high for exactly the one cycle in which its new value appears. It is raised when the exact result of the operation lies outside the signed 32-bit range.
- R8: With saturation enabled for an accumulator (`cfg_sat_a`/`cfg_sat_b`) and `cfg_super_sat` = 0, a result outside the signed 32-bit range is clamped to 0x007FFFFFFF or 0xFF80000000, and the saturation pulse is raised. With saturation disabled the result wraps modulo 2^40 and no saturation pulse is raised.
- R9: With `cfg_super_sat` = 1 the clamp point moves to the signed 40-bit range, 0x7FFFFFFFFF / 0x8000000000.
- R10: `wb_word` is bits 31..16 of the accumulator chosen by `wb_sel`, rounded on bits 15..0. With `cfg_conv_round` = 0, a remainder of 0x8000 or more rounds up.
- R11: With `cfg_conv_round` = 1 a remainder above 0x8000 rounds up and one below rounds down. A remainder of exactly 0x8000 rounds to the even result.
- R12: With `cfg_sat_wb` = 1 a rounded value outside the signed 32-bit range gives 0x7FFF or 0x8000 on `wb_word`. With it 0 the rounded bits 31..16 are passed through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 3 | Operation: 0 none, 1 load, 2 add product, 3 subtract product, 4 clear, 5 add other, 6 subtract other, 7 negate |
| acc_sel | input | 1 | Target accumulator, 0 = A, 1 = B |
| opnd_x | input | 16 | First multiplier operand |
| opnd_y | input | 16 | Second multiplier operand |
| cfg_frac | input | 1 | 1 = fractional multiply (product doubled) |
| cfg_unsigned | input | 1 | 1 = operands zero-extended |
| cfg_conv_round | input | 1 | 1 = round half to even on read-back |
| cfg_sat_a | input | 1 | Saturation enable for accumulator A |
| cfg_sat_b | input | 1 | Saturation enable for accumulator B |
| cfg_super_sat | input | 1 | 1 = clamp at 40 bits instead of 32 |
| cfg_sat_wb | input | 1 | 1 = clamp the read-back word to 16-bit range |
| wb_sel | input | 1 | Accumulator reduced onto `wb_word`, 0 = A, 1 = B |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |
| wb_word | output | 16 | Rounded, optionally clamped read-back word |
| ovf_a | output | 1 | Overflow pulse for A |
| ovf_b | output | 1 | Overflow pulse for B |
| sat_a | output | 1 | Saturation pulse for A |
| sat_b | output | 1 | Saturation pulse for B |

## Verification
An operation presented before a rising edge shows on `acc_a`/`acc_b`, and on the pulse outputs, right after that edge, one register deep. The pulses drop again after the following edge if no operation targets that accumulator. The bench drives on the falling edge and samples both accumulators and all four pulses on the next falling edge, so each check falls inside that one-cycle window. `wb_word` has no register: it is sampled a short delay after `wb_sel` or the rounding settings change, while no edge intervenes.

// File: rtl/dsp_mac_pkg.sv
package dsp_mac_pkg;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_MPY = 3'd1,
    OP_MAC = 3'd2,
    OP_MSC = 3'd3,
    OP_CLR = 3'd4,
    OP_ADD = 3'd5,
    OP_SUB = 3'd6,
    OP_NEG = 3'd7
  } mac_op_e;

  localparam int unsigned LANES = 2;

endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int OPND_W = 16,
  parameter int ACC_W  = 40
) (
  input  logic [OPND_W-1:0] x,
  input  logic [OPND_W-1:0] y,
  input  logic              uns,
  input  logic              frac,
  output logic [ACC_W-1:0]  prod
);
  localparam int MUL_W  = OPND_W + 1;
  localparam int PROD_W = 2 * MUL_W;

  function automatic logic [MUL_W-1:0] widen(input logic [OPND_W-1:0] v, input logic zext);
    return {(zext ? 1'b0 : v[OPND_W-1]), v};
  endfunction

  logic signed [MUL_W-1:0]  xw, yw;
  logic signed [PROD_W-1:0] raw;
  logic signed [ACC_W-1:0]  ext;

  always_comb begin
    xw   = $signed(widen(x, uns));
    yw   = $signed(widen(y, uns));
    raw  = xw * yw;
    ext  = $signed({{(ACC_W-PROD_W){raw[PROD_W-1]}}, raw});
    prod = frac ? ext <<< 1 : ext;
  end

endmodule

// File: rtl/mac_acc_lane.sv
module mac_acc_lane
  import dsp_mac_pkg::*;
#(
  parameter int ACC_W    = 40,
  parameter int NORM_BIT = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [2:0]       op,
  input  logic [ACC_W-1:0] prod,
  input  logic [ACC_W-1:0] other,
  input  logic             sat_en,
  input  logic             super_sat,
  output logic [ACC_W-1:0] acc,
  output logic             ovf_p,
  output logic             sat_p
);
  localparam int SUM_W = ACC_W + 1;

  function automatic logic fits(input logic signed [SUM_W-1:0] v, input int top);
    logic ok;
    ok = 1'b1;
    for (int b = 0; b < SUM_W; b++)
      if (b > top && v[b] != v[top]) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic signed [SUM_W-1:0] clamp(input logic signed [SUM_W-1:0] v, input int top);
    logic signed [SUM_W-1:0] one;
    one = 1;
    if (v[SUM_W-1]) return -(one <<< top);
    return (one <<< top) - one;
  endfunction

  logic signed [SUM_W-1:0] own_s, oth_s, prd_s, exact;
  logic                    ovf_ev, sat_ev;
  logic [ACC_W-1:0]        acc_nxt;
  int                      lim;

  always_comb begin
    own_s = $signed({acc[ACC_W-1], acc});
    oth_s = $signed({other[ACC_W-1], other});
    prd_s = $signed({prod[ACC_W-1], prod});
    case (mac_op_e'(op))
      OP_MPY:  exact = prd_s;
      OP_MAC:  exact = own_s + prd_s;
      OP_MSC:  exact = own_s - prd_s;
      OP_ADD:  exact = own_s + oth_s;
      OP_SUB:  exact = own_s - oth_s;
      OP_NEG:  exact = -own_s;
      default: exact = '0;
    endcase
    lim     = super_sat ? ACC_W - 1 : NORM_BIT;
    ovf_ev  = upd && !fits(exact, NORM_BIT);
    sat_ev  = upd && sat_en && !fits(exact, lim);
    acc_nxt = sat_ev ? clamp(exact, lim) : exact[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc   <= '0;
      ovf_p <= 1'b0;
      sat_p <= 1'b0;
    end else begin
      if (upd) acc <= acc_nxt;
      ovf_p <= ovf_ev;
      sat_p <= sat_ev;
    end
  end

endmodule

// File: rtl/mac_wb_round.sv
module mac_wb_round #(
  parameter int ACC_W    = 40,
  parameter int NORM_BIT = 31,
  parameter int WB_W     = 16
) (
  input  logic [ACC_W-1:0] acc,
  input  logic             conv,
  input  logic             sat_en,
  output logic [WB_W-1:0]  word
);
  localparam int LSB   = NORM_BIT + 1 - WB_W;
  localparam int RND_W = ACC_W + 1;

  function automatic logic round_up(input logic [ACC_W-1:0] v, input logic even_mode);
    logic [LSB-1:0] rem, half;
    rem  = v[LSB-1:0];
    half = {1'b1, {(LSB-1){1'b0}}};
    if (even_mode) return (rem > half) || (rem == half && v[LSB]);
    return rem[LSB-1];
  endfunction

  function automatic logic in_word(input logic [RND_W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int b = NORM_BIT + 1; b < RND_W; b++)
      if (v[b] != v[NORM_BIT]) ok = 1'b0;
    return ok;
  endfunction

  logic [RND_W-1:0] rnd, inc;

  always_comb begin
    inc  = '0;
    inc[LSB] = round_up(acc, conv);
    rnd  = {acc[ACC_W-1], acc} + inc;
    if (sat_en && !in_word(rnd))
      word = rnd[RND_W-1] ? {1'b1, {(WB_W-1){1'b0}}} : {1'b0, {(WB_W-1){1'b1}}};
    else
      word = rnd[NORM_BIT:LSB];
  end

endmodule

// File: rtl/dsp_mac_core.sv
module dsp_mac_core
  import dsp_mac_pkg::*;
#(
  parameter int OPND_W = 16,
  parameter int GUARD_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          op_valid,
  input  logic [2:0]                    op_code,
  input  logic                          acc_sel,
  input  logic [OPND_W-1:0]             opnd_x,
  input  logic [OPND_W-1:0]             opnd_y,
  input  logic                          cfg_frac,
  input  logic                          cfg_unsigned,
  input  logic                          cfg_conv_round,
  input  logic                          cfg_sat_a,
  input  logic                          cfg_sat_b,
  input  logic                          cfg_super_sat,
  input  logic                          cfg_sat_wb,
  input  logic                          wb_sel,
  output logic [2*OPND_W+GUARD_W-1:0]   acc_a,
  output logic [2*OPND_W+GUARD_W-1:0]   acc_b,
  output logic [OPND_W-1:0]             wb_word,
  output logic                          ovf_a,
  output logic                          ovf_b,
  output logic                          sat_a,
  output logic                          sat_b
);
  localparam int ACC_W    = 2 * OPND_W + GUARD_W;
  localparam int NORM_BIT = 2 * OPND_W - 1;

  logic [ACC_W-1:0]             prod;
  logic [LANES-1:0][ACC_W-1:0]  acc_q;
  logic [LANES-1:0]             ovf_q, sat_q, sat_en_v;
  logic                         op_live;

  assign op_live  = op_valid && (op_code != OP_NOP);
  assign sat_en_v = {cfg_sat_b, cfg_sat_a};

  mac_mult #(.OPND_W(OPND_W), .ACC_W(ACC_W)) u_mult (
    .x    (opnd_x),
    .y    (opnd_y),
    .uns  (cfg_unsigned),
    .frac (cfg_frac),
    .prod (prod)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    mac_acc_lane #(.ACC_W(ACC_W), .NORM_BIT(NORM_BIT)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd       (op_live && (acc_sel == 1'(i))),
      .op        (op_code),
      .prod      (prod),
      .other     (acc_q[LANES-1-i]),
      .sat_en    (sat_en_v[i]),
      .super_sat (cfg_super_sat),
      .acc       (acc_q[i]),
      .ovf_p     (ovf_q[i]),
      .sat_p     (sat_q[i])
    );
  end

  mac_wb_round #(.ACC_W(ACC_W), .NORM_BIT(NORM_BIT), .WB_W(OPND_W)) u_wb (
    .acc    (acc_q[wb_sel]),
    .conv   (cfg_conv_round),
    .sat_en (cfg_sat_wb),
    .word   (wb_word)
  );

  assign acc_a = acc_q[0];
  assign acc_b = acc_q[1];
  assign ovf_a = ovf_q[0];
  assign ovf_b = ovf_q[1];
  assign sat_a = sat_q[0];
  assign sat_b = sat_q[1];

endmodule

// File: rtl/dsp_mac_core_chk.sv
module dsp_mac_core_chk
  import dsp_mac_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [2:0]  op_code,
  input logic        acc_sel,
  input logic        cfg_super_sat,
  input logic [39:0] acc_a,
  input logic [39:0] acc_b,
  input logic        ovf_a,
  input logic        ovf_b,
  input logic        sat_a,
  input logic        sat_b
);

  p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == OP_CLR && !acc_sel |=> acc_a == 40'd0);

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(acc_a) && $stable(acc_b));

  p_b_untouched_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !acc_sel |=> $stable(acc_b));

  p_a_untouched_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && acc_sel |=> $stable(acc_a));

  p_sat_has_ovf_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sat_a |-> ovf_a);

  p_sat_has_ovf_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sat_b |-> ovf_b);

  p_clamp_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sat_a && !cfg_super_sat |-> (acc_a == 40'h007FFFFFFF || acc_a == 40'hFF80000000));

  p_clamp_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sat_a && cfg_super_sat |-> (acc_a == 40'h7FFFFFFFFF || acc_a == 40'h8000000000));

  p_pulse_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_b) |-> $past(op_valid && acc_sel));

endmodule

bind dsp_mac_core dsp_mac_core_chk u_chk (.*);

// File: tb/dsp_mac_core_bench.sv
module dsp_mac_core_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        op_valid = 0, acc_sel = 0, wb_sel = 0;
  logic [2:0]  op_code = 0;
  logic [15:0] opnd_x = 0, opnd_y = 0;
  logic        cfg_frac = 0, cfg_unsigned = 0, cfg_conv_round = 0;
  logic        cfg_sat_a = 0, cfg_sat_b = 0, cfg_super_sat = 0, cfg_sat_wb = 0;
  logic [39:0] acc_a, acc_b;
  logic [15:0] wb_word;
  logic        ovf_a, ovf_b, sat_a, sat_b;

  int checks = 0, errors = 0;
  bit done = 0;
  longint ma = 0, mb = 0;

  dsp_mac_core u_dsp_mac_core (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic longint sx40(logic [39:0] v);
    return longint'($signed(v));
  endfunction

  function automatic longint wrap40(longint v);
    longint w;
    w = v & ((64'sd1 <<< 40) - 1);
    if (w >= (64'sd1 <<< 39)) w -= (64'sd1 <<< 40);
    return w;
  endfunction

  task automatic run_op(string req, int op, bit sel, logic [15:0] x, logic [15:0] y);
    longint px, py, p, own, oth, ex, lim, res;
    bit en, e_ovf, e_sat;
    px = cfg_unsigned ? longint'(x) : longint'($signed(x));
    py = cfg_unsigned ? longint'(y) : longint'($signed(y));
    p = px * py;
    if (cfg_frac) p = p * 2;
    own = sel ? mb : ma;
    oth = sel ? ma : mb;
    case (op)
      1: ex = p;
      2: ex = own + p;
      3: ex = own - p;
      4: ex = 0;
      5: ex = own + oth;
      6: ex = own - oth;
      7: ex = -own;
      default: ex = own;
    endcase
    e_ovf = (op != 0) && (ex > 64'sd2147483647 || ex < -64'sd2147483648);
    en = sel ? cfg_sat_b : cfg_sat_a;
    lim = cfg_super_sat ? (64'sd1 <<< 39) : (64'sd1 <<< 31);
    e_sat = 0;
    if (op != 0 && en && ex >= lim) begin res = lim - 1; e_sat = 1; end
    else if (op != 0 && en && ex < -lim) begin res = -lim; e_sat = 1; end
    else res = wrap40(ex);
    if (sel) mb = res; else ma = res;
    @(negedge clk);
    op_valid = 1; op_code = 3'(op); acc_sel = sel; opnd_x = x; opnd_y = y;
    @(negedge clk);
    op_valid = 0;
    check({req, " acc_a"}, sx40(acc_a), ma);
    check({req, " acc_b"}, sx40(acc_b), mb);
    check({req, " ovf"}, sel ? ovf_b : ovf_a, e_ovf);
    check({req, " sat"}, sel ? sat_b : sat_a, e_sat);
    check({req, " quiet lane"}, sel ? (ovf_a | sat_a) : (ovf_b | sat_b), 0);
  endtask

  task automatic check_wb(string req, bit sel);
    longint v, base, rem;
    v = sel ? mb : ma;
    wb_sel = sel;
    #1;
    rem = v & 64'hFFFF;
    base = v >>> 16;
    if (cfg_conv_round) begin
      if (rem > 64'h8000 || (rem == 64'h8000 && base[0])) base++;
    end else if (rem >= 64'h8000) base++;
    if (cfg_sat_wb && base > 32767) base = 32767;
    else if (cfg_sat_wb && base < -32768) base = -32768;
    check(req, longint'(wb_word), base & 64'hFFFF);
  endtask

  task automatic t_reset_r1;
    check("R1 acc_a in reset", longint'(acc_a), 0);
    @(negedge clk); rst_n = 1; @(negedge clk);
    check("R1 acc_a after reset", longint'(acc_a), 0);
    check("R1 acc_b after reset", longint'(acc_b), 0);
    check("R1 pulses after reset", longint'({ovf_a, ovf_b, sat_a, sat_b}), 0);
  endtask

  task automatic t_multiply_r2_r3;
    run_op("R2 signed load", 1, 0, 16'hFFFD, 16'd5);
    run_op("R2 signed neg*neg", 1, 1, 16'h8000, 16'hFFFF);
    cfg_unsigned = 1;
    run_op("R2 unsigned load", 1, 0, 16'hFFFF, 16'hFFFF);
    cfg_unsigned = 0; cfg_frac = 1;
    run_op("R3 fractional", 1, 1, 16'h4000, 16'h4000);
    run_op("R3 fractional mac", 2, 1, 16'hC000, 16'h2000);
    cfg_frac = 0;
  endtask

  task automatic t_accumulate_r4;
    run_op("R4 mac", 2, 0, 16'd100, 16'd200);
    run_op("R4 msc", 3, 0, 16'd7, 16'hFFF0);
    run_op("R4 msc b", 3, 1, 16'd1000, 16'd1000);
  endtask

  task automatic t_clear_hold_r5;
    run_op("R5 nop code", 0, 0, 16'd9, 16'd9);
    @(negedge clk); @(negedge clk);
    check("R5 idle acc_a", sx40(acc_a), ma);
    check("R5 idle acc_b", sx40(acc_b), mb);
    run_op("R5 clear b", 4, 1, 16'd0, 16'd0);
  endtask

  task automatic t_acc_ops_r6;
    run_op("R6 load", 1, 1, 16'd300, 16'd3);
    run_op("R6 add", 5, 0, 16'd0, 16'd0);
    run_op("R6 sub", 6, 1, 16'd0, 16'd0);
    run_op("R6 neg", 7, 0, 16'd0, 16'd0);
  endtask

  task automatic t_saturate_r7_r8;
    cfg_frac = 1;
    run_op("R7 ovf no sat", 1, 0, 16'h8000, 16'h8000);
    cfg_sat_b = 1;
    run_op("R8 clamp high", 1, 1, 16'h8000, 16'h8000);
    run_op("R8 clamp low", 3, 1, 16'h7FFF, 16'h7FFF);
    run_op("R8 in range", 1, 1, 16'h0100, 16'h0100);
    cfg_frac = 0;
    mb = mb;
    for (int k = 0; k < 14; k++) run_op("R8 wrap growth", 5, 0, 16'd0, 16'd0);
    cfg_sat_b = 0;
  endtask

  task automatic t_super_r9;
    run_op("R9 clear", 4, 0, 16'd0, 16'd0);
    cfg_frac = 1;
    run_op("R9 seed a", 1, 0, 16'h8000, 16'h8000);
    run_op("R9 seed b", 1, 1, 16'h8000, 16'h8000);
    cfg_frac = 0; cfg_sat_a = 1; cfg_super_sat = 1;
    for (int k = 0; k < 16; k++) run_op("R9 super growth", 5, k[0], 16'd0, 16'd0);
    run_op("R9 neg max", 7, 0, 16'd0, 16'd0);
    cfg_sat_a = 0; cfg_super_sat = 0;
  endtask

  task automatic t_round_r10_r11_r12;
    cfg_unsigned = 1;
    run_op("R10 tie odd", 1, 0, 16'd3, 16'h8000);
    run_op("R10 tie even", 1, 1, 16'd5, 16'h8000);
    cfg_conv_round = 0;
    check_wb("R10 conv tie odd", 0);
    check_wb("R10 conv tie even", 1);
    cfg_conv_round = 1;
    check_wb("R11 even tie odd", 0);
    check_wb("R11 even tie even", 1);
    run_op("R11 above half", 2, 1, 16'd1, 16'd1);
    check_wb("R11 above half", 1);
    run_op("R11 below half", 3, 1, 16'd2, 16'd1);
    check_wb("R11 below half", 1);
    cfg_unsigned = 0; cfg_conv_round = 0;
    run_op("R10 negative", 1, 0, 16'hFFF1, 16'd1);
    check_wb("R10 negative", 0);
    cfg_frac = 1;
    run_op("R12 big", 1, 0, 16'h8000, 16'h8000);
    cfg_sat_wb = 0;
    check_wb("R12 pass through", 0);
    cfg_sat_wb = 1;
    check_wb("R12 clamp high", 0);
    run_op("R12 big neg", 7, 0, 16'd0, 16'd0);
    run_op("R12 more neg", 3, 0, 16'h4000, 16'h4000);
    check_wb("R12 clamp low", 0);
    cfg_frac = 0; cfg_sat_wb = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_r1();
    t_multiply_r2_r3();
    t_accumulate_r4();
    t_clear_hold_r5();
    t_acc_ops_r6();
    t_saturate_r7_r8();
    t_super_r9();
    t_round_r10_r11_r12();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule